// File: doc/BRIEF.md
# Periodic DMA Write Sequencer

This block orders, sizes and aligns the memory writes that a USB host controller's periodic DMA engine issues after a bus transaction has finished. A completion event carries four things: the kind of control structure, the structure's base address, the address of the inbound data buffer and the inbound byte count. From these the block emits one or more write requests on a valid/ready port. Each request carries an address, a DWord count and the byte enables of its final DWord.

The inbound payload goes out first, cut into chunks that never straddle a 64-byte (16-DWord) boundary. The block then writes back the structure's status window. The offset and size of that window depend on the structure kind. A single-cycle done pulse marks the end of the sequence. A new event is accepted only while the block is idle. Data sourcing, arbitration against other engines and schedule walking belong to other blocks.

Top module: `pdw_write_seq`

## Requirements
- R1: A write request is raised only after a completion event has been taken (`evt_valid` and `evt_ready` high at a clock edge), and `evt_ready` is high only while no sequence is in progress.
- R2: For one event, every data write is accepted before the status write, and the status write is the last request of the sequence.
- R3: No data request crosses a 64-byte boundary, and every data request carries 1 to 16 DWords.
- R4: Data requests start at the buffer address (DWord aligned) and are contiguous. Each one fills up to the next 64-byte boundary or covers what remains, and together they cover ceil(bytes/4) DWords.
- R5: `wr_be` gives the enables of a request's last DWord. On the final data request it is 4'hF, 4'h1, 4'h3 or 4'h7 for bytes mod 4 = 0, 1, 2 or 3. On every other request it is 4'hF.
- R6: Kind 0 (isochronous descriptor): the status write is 1 DWord at base + 04h + 4 × microframe.
- R7: Kind 1 (split-isochronous descriptor): the status write is 3 DWords at base + 0Ch.
- R8: Kind 2 (interrupt queue head overlay, 64-bit layout): the status write is 14 DWords at base + 0Ch.
- R9: Kind 3 (interrupt transfer descriptor): the status write is 3 DWords at base + 04h.
- R10: A byte count of zero produces no data request, and the status write comes first.
- R11: A request that is not acknowledged holds `wr_valid`, `wr_addr`, `wr_dwords`, `wr_be` and `wr_is_status` unchanged in the next cycle.
- R12: `done` is high for exactly the one cycle after the status write is accepted, and `evt_ready` returns in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Completion event present |
| evt_ready | output | 1 | Block idle, event can be taken |
| evt_kind | input | 2 | Structure kind: 0 iso, 1 split-iso, 2 queue head, 3 transfer descriptor |
| evt_base | input | 32 | Structure base byte address |
| evt_buf | input | 32 | Inbound data buffer byte address |
| evt_bytes | input | 11 | Inbound byte count, 0 to 1028 |
| evt_uframe | input | 3 | Microframe just executed (kind 0) |
| wr_valid | output | 1 | Write request present |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 32 | Request start byte address |
| wr_dwords | output | 5 | Request length in DWords |
| wr_be | output | 4 | Byte enables of the request's last DWord |
| wr_is_status | output | 1 | Request is the status write-back |
| done | output | 1 | Sequence finished (one cycle) |

## Verification
Two functions can fall in the same cycle: the acknowledge of the final status write, and a next completion event that is already waiting on `evt_valid`. The bench provokes this by keeping `evt_valid` high through whole sequences. It counts every cycle in which the event handshake completes and requires exactly one acceptance per sequence. No acceptance may occur before the done pulse. Random acknowledge gaps also place the last data chunk's acceptance in the same cycle as the switch to the status window. The recorded request list is compared entry by entry against a model computed in the bench.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  localparam int PDW_ADDR_W   = 32;
  localparam int PDW_LEN_W    = 11;
  localparam int PDW_CHUNK_DW = 16;
  localparam int PDW_CNT_W    = $clog2(PDW_CHUNK_DW) + 1;

  typedef enum logic [1:0] {
    K_ISO   = 2'd0,
    K_SPLIT = 2'd1,
    K_QHEAD = 2'd2,
    K_QTD   = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DATA = 2'd1,
    S_STAT = 2'd2,
    S_DONE = 2'd3
  } seq_st_e;

  // enables of the final DWord given the byte count modulo four
  function automatic logic [3:0] tail_be(input logic [1:0] rem);
    case (rem)
      2'd1:    tail_be = 4'h1;
      2'd2:    tail_be = 4'h3;
      2'd3:    tail_be = 4'h7;
      default: tail_be = 4'hF;
    endcase
  endfunction

  // byte offset of the status window inside the structure
  function automatic logic [7:0] status_off(input kind_e k, input logic [2:0] uf);
    case (k)
      K_ISO:   status_off = 8'h04 + {3'd0, uf, 2'b00};
      K_SPLIT: status_off = 8'h0C;
      K_QHEAD: status_off = 8'h0C;
      default: status_off = 8'h04;
    endcase
  endfunction

  // status window length in DWords
  function automatic logic [PDW_CNT_W-1:0] status_dw(input kind_e k);
    case (k)
      K_ISO:   status_dw = PDW_CNT_W'(1);
      K_QHEAD: status_dw = PDW_CNT_W'(14);
      default: status_dw = PDW_CNT_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/pdw_chunk_calc.sv
module pdw_chunk_calc
  import pdw_pkg::*;
#(
  parameter int ADDR_W   = PDW_ADDR_W,
  parameter int LEN_W    = PDW_LEN_W,
  parameter int CHUNK_DW = PDW_CHUNK_DW,
  parameter int CNT_W    = PDW_CNT_W
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  rem_bytes,
  output logic [CNT_W-1:0]  chunk_dw,
  output logic [3:0]        chunk_be,
  output logic              chunk_last,
  output logic [ADDR_W-1:0] next_addr,
  output logic [LEN_W-1:0]  next_rem
);
  localparam int SEG_W = $clog2(CHUNK_DW);

  logic [LEN_W:0]   rem_dw;
  logic [LEN_W:0]   room_dw;
  logic [SEG_W-1:0] seg_pos;

  always_comb begin
    seg_pos    = cur_addr[SEG_W+1:2];
    room_dw    = (LEN_W+1)'(CHUNK_DW) - (LEN_W+1)'(seg_pos);
    rem_dw     = ({1'b0, rem_bytes} + (LEN_W+1)'(3)) >> 2;
    chunk_last = (rem_dw <= room_dw);
    chunk_dw   = chunk_last ? CNT_W'(rem_dw) : CNT_W'(room_dw);
    chunk_be   = chunk_last ? tail_be(rem_bytes[1:0]) : 4'hF;
    next_addr  = cur_addr + (ADDR_W'(chunk_dw) << 2);
    next_rem   = chunk_last ? '0 : rem_bytes - (LEN_W'(chunk_dw) << 2);
  end
endmodule

// File: rtl/pdw_status_calc.sv
module pdw_status_calc
  import pdw_pkg::*;
#(
  parameter int ADDR_W = PDW_ADDR_W,
  parameter int CNT_W  = PDW_CNT_W
) (
  input  kind_e             kind,
  input  logic [ADDR_W-1:0] base,
  input  logic [2:0]        uframe,
  output logic [ADDR_W-1:0] st_addr,
  output logic [CNT_W-1:0]  st_dw
);
  always_comb begin
    st_addr = base + ADDR_W'(status_off(kind, uframe));
    st_dw   = status_dw(kind);
  end
endmodule

// File: rtl/pdw_seq_ctrl.sv
module pdw_seq_ctrl
  import pdw_pkg::*;
#(
  parameter int ADDR_W = PDW_ADDR_W,
  parameter int LEN_W  = PDW_LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  kind_e             evt_kind,
  input  logic [ADDR_W-1:0] evt_base,
  input  logic [ADDR_W-1:0] evt_buf,
  input  logic [LEN_W-1:0]  evt_bytes,
  input  logic [2:0]        evt_uframe,
  input  logic              wr_ready,
  input  logic              chunk_last,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [LEN_W-1:0]  next_rem,
  output seq_st_e           st,
  output logic              evt_take,
  output logic              data_fire,
  output logic              stat_fire,
  output logic              rem_zero,
  output kind_e             kind_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [2:0]        uf_q,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  rem_bytes
);
  assign evt_take  = (st == S_IDLE) && evt_valid;
  assign data_fire = (st == S_DATA) && wr_ready;
  assign stat_fire = (st == S_STAT) && wr_ready;
  assign rem_zero  = (rem_bytes == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind_q    <= K_ISO;
      base_q    <= '0;
      uf_q      <= '0;
      cur_addr  <= '0;
      rem_bytes <= '0;
    end else begin
      case (st)
        S_IDLE: if (evt_take) begin
          kind_q    <= evt_kind;
          base_q    <= evt_base;
          uf_q      <= evt_uframe;
          cur_addr  <= {evt_buf[ADDR_W-1:2], 2'b00};
          rem_bytes <= evt_bytes;
          st        <= (evt_bytes == '0) ? S_STAT : S_DATA;
        end
        S_DATA: if (data_fire) begin
          cur_addr  <= next_addr;
          rem_bytes <= next_rem;
          if (chunk_last) st <= S_STAT;
        end
        S_STAT: if (stat_fire) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: status phase only once the inbound data is used up
  p_data_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STAT) |-> rem_zero);
  // R12: status acceptance leads to the done state, which then frees the port
  p_done_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fire |=> (st == S_DONE) ##1 (st == S_IDLE));
endmodule

// File: rtl/pdw_write_seq.sv
module pdw_write_seq
  import pdw_pkg::*;
#(
  parameter int ADDR_W   = PDW_ADDR_W,
  parameter int LEN_W    = PDW_LEN_W,
  parameter int CHUNK_DW = PDW_CHUNK_DW,
  parameter int CNT_W    = PDW_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [1:0]        evt_kind,
  input  logic [ADDR_W-1:0] evt_base,
  input  logic [ADDR_W-1:0] evt_buf,
  input  logic [LEN_W-1:0]  evt_bytes,
  input  logic [2:0]        evt_uframe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CNT_W-1:0]  wr_dwords,
  output logic [3:0]        wr_be,
  output logic              wr_is_status,
  output logic              done
);
  localparam int SEG_W = $clog2(CHUNK_DW);

  seq_st_e           st;
  logic              evt_take, data_fire, stat_fire, rem_zero;
  kind_e             kind_q;
  logic [ADDR_W-1:0] base_q, cur_addr, next_addr, st_addr;
  logic [2:0]        uf_q;
  logic [LEN_W-1:0]  rem_bytes, next_rem;
  logic [CNT_W-1:0]  chunk_dw, st_dw;
  logic [3:0]        chunk_be;
  logic              chunk_last;

  pdw_seq_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid),
    .evt_kind(kind_e'(evt_kind)), .evt_base(evt_base), .evt_buf(evt_buf),
    .evt_bytes(evt_bytes), .evt_uframe(evt_uframe), .wr_ready(wr_ready),
    .chunk_last(chunk_last), .next_addr(next_addr), .next_rem(next_rem),
    .st(st), .evt_take(evt_take), .data_fire(data_fire), .stat_fire(stat_fire),
    .rem_zero(rem_zero), .kind_q(kind_q), .base_q(base_q), .uf_q(uf_q),
    .cur_addr(cur_addr), .rem_bytes(rem_bytes)
  );

  pdw_chunk_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_DW(CHUNK_DW),
                   .CNT_W(CNT_W)) u_chunk (
    .cur_addr(cur_addr), .rem_bytes(rem_bytes), .chunk_dw(chunk_dw),
    .chunk_be(chunk_be), .chunk_last(chunk_last), .next_addr(next_addr),
    .next_rem(next_rem)
  );

  pdw_status_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stat (
    .kind(kind_q), .base(base_q), .uframe(uf_q), .st_addr(st_addr), .st_dw(st_dw)
  );

  always_comb begin
    evt_ready    = (st == S_IDLE);
    wr_is_status = (st == S_STAT);
    wr_valid     = (st == S_DATA) || (st == S_STAT);
    done         = (st == S_DONE);
    wr_addr      = wr_is_status ? st_addr : cur_addr;
    wr_dwords    = wr_is_status ? st_dw : chunk_dw;
    wr_be        = wr_is_status ? 4'hF : chunk_be;
  end

  // R1: a request only appears after an event handshake or an earlier request
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !$past(wr_valid)) |-> $past(evt_take));
  // R3: data chunks stay inside one 64-byte segment
  p_segment_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_is_status) |->
      (wr_dwords != '0) &&
      ((CNT_W+1)'(wr_addr[SEG_W+1:2]) + (CNT_W+1)'(wr_dwords) <= (CNT_W+1)'(CHUNK_DW)));
  // R5: status writes carry full enables
  p_status_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_is_status) |-> (wr_be == 4'hF));
  // R11: an unacknowledged request is held
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_dwords)
                                && $stable(wr_be) && $stable(wr_is_status));
  // R12: done is a single-cycle pulse after the status acceptance
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && evt_ready);
endmodule

// File: tb/pdw_write_seq_tb.sv
module pdw_write_seq_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic evt_valid = 0, evt_ready;
  logic [1:0] evt_kind = 0;
  logic [31:0] evt_base = 0, evt_buf = 0;
  logic [10:0] evt_bytes = 0;
  logic [2:0] evt_uframe = 0;
  logic wr_valid, wr_ready = 0;
  logic [31:0] wr_addr;
  logic [4:0] wr_dwords;
  logic [3:0] wr_be;
  logic wr_is_status, done;

  int n_chk = 0, n_fail = 0;
  bit summary_done = 0;

  always #2 clk = ~clk;

  pdw_write_seq u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_kind(evt_kind), .evt_base(evt_base), .evt_buf(evt_buf),
    .evt_bytes(evt_bytes), .evt_uframe(evt_uframe), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_dwords(wr_dwords), .wr_be(wr_be),
    .wr_is_status(wr_is_status), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  logic [31:0] lg_addr [0:39];
  int          lg_dw   [0:39];
  logic [3:0]  lg_be   [0:39];
  bit          lg_st   [0:39];
  int          lg_n = 0;
  int          accepts = 0;
  bit          want_done = 0, held = 0;
  logic [31:0] h_addr; logic [4:0] h_dw; logic [3:0] h_be; logic h_st;
  bit          ready_rand = 1;

  always @(posedge clk) begin
    #1;
    if (ready_rand) wr_ready = ($urandom_range(0, 3) != 0);
  end

  always @(negedge clk) if (rst_n) begin
    if (want_done) begin
      chk(done === 1'b1, "R12", "done after status", done, 1);
      want_done = 0;
    end else if (done) chk(0, "R12", "unexpected done", done, 0);
    if (held)
      chk(wr_valid && wr_addr == h_addr && wr_dwords == h_dw && wr_be == h_be &&
          wr_is_status == h_st, "R11", "held request", wr_addr, h_addr);
    if (wr_valid && evt_ready) chk(0, "R1", "ready while busy", evt_ready, 0);
    if (wr_valid && wr_ready && lg_n < 40) begin
      lg_addr[lg_n] = wr_addr; lg_dw[lg_n] = wr_dwords;
      lg_be[lg_n] = wr_be; lg_st[lg_n] = wr_is_status; lg_n++;
      if (wr_is_status) want_done = 1;
    end
    held = wr_valid && !wr_ready;
    h_addr = wr_addr; h_dw = wr_dwords; h_be = wr_be; h_st = wr_is_status;
    if (evt_valid && evt_ready) accepts++;
  end

  // ---------------- model ----------------
  logic [31:0] ex_addr [0:39];
  int          ex_dw   [0:39];
  logic [3:0]  ex_be   [0:39];
  bit          ex_st   [0:39];
  int          ex_n;

  function automatic logic [3:0] end_be(input int left);
    case (left % 4) 1: return 4'b0001; 2: return 4'b0011; 3: return 4'b0111;
      default: return 4'b1111; endcase
  endfunction

  task automatic build(input int kind, input logic [31:0] base, buf_a,
                       input int bytes, input int uf);
    logic [31:0] a = buf_a & ~32'd3;
    int left = bytes;
    ex_n = 0;
    while (left > 0) begin
      int need = (left + 3) / 4;
      int room = ((a | 32'd63) + 1 - a) / 4;
      int n = (need < room) ? need : room;
      ex_addr[ex_n] = a; ex_dw[ex_n] = n; ex_st[ex_n] = 0;
      ex_be[ex_n] = (n == need) ? end_be(left) : 4'hF;
      ex_n++;
      a += n * 4;
      left = (n == need) ? 0 : left - n * 4;
    end
    ex_st[ex_n] = 1; ex_be[ex_n] = 4'hF;
    case (kind)
      0: begin ex_addr[ex_n] = base + 4 + 4 * uf; ex_dw[ex_n] = 1; end
      1: begin ex_addr[ex_n] = base + 12; ex_dw[ex_n] = 3; end
      2: begin ex_addr[ex_n] = base + 12; ex_dw[ex_n] = 14; end
      default: begin ex_addr[ex_n] = base + 4; ex_dw[ex_n] = 3; end
    endcase
    ex_n++;
  endtask

  task automatic run(input int kind, input logic [31:0] base, buf_a,
                     input int bytes, input int uf, input bit hold);
    string sreq;
    build(kind, base, buf_a, bytes, uf);
    @(posedge clk); #1;
    lg_n = 0; accepts = 0;
    evt_kind = kind[1:0]; evt_base = base; evt_buf = buf_a;
    evt_bytes = bytes[10:0]; evt_uframe = uf[2:0]; evt_valid = 1;
    do @(negedge clk); while (!evt_ready);
    if (!hold) begin @(posedge clk); #1; evt_valid = 0; end
    do @(negedge clk); while (!done);
    if (hold) begin @(posedge clk); #1; evt_valid = 0; end
    chk(accepts == 1, "R1", "accepts per sequence", accepts, 1);
    chk(lg_n == ex_n, (bytes == 0) ? "R10" : "R2", "request count", lg_n, ex_n);
    sreq = (kind == 0) ? "R6" : (kind == 1) ? "R7" : (kind == 2) ? "R8" : "R9";
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      if (ex_st[i]) begin
        chk(lg_st[i], "R2", "status last", lg_st[i], 1);
        chk(lg_addr[i] == ex_addr[i] && lg_dw[i] == ex_dw[i], sreq,
            "status addr", lg_addr[i], ex_addr[i]);
      end else begin
        chk(!lg_st[i] && lg_addr[i] == ex_addr[i] && lg_dw[i] == ex_dw[i], "R4",
            "data chunk", lg_addr[i], ex_addr[i]);
        chk(lg_dw[i] >= 1 && ((lg_addr[i] % 64) / 4 + lg_dw[i]) <= 16, "R3",
            "segment", lg_dw[i], ex_dw[i]);
      end
      chk(lg_be[i] == ex_be[i], "R5", "byte enables", lg_be[i], ex_be[i]);
    end
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !summary_done) begin
      chk(0, "WDOG", "timeout", cyc, 150000);
      summary_done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0DA7_5EED));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(evt_ready && !wr_valid && !done, "R1", "reset state", {evt_ready, wr_valid, done}, 3'b100);
    // directed corners
    run(0, 32'h0000_2000, 32'h0001_0000, 0, 7, 0);          // R10, R6 top microframe
    run(1, 32'h0000_3000, 32'h0001_003C, 8, 0, 0);          // R4 crossing at 64 B
    run(2, 32'h0000_4000, 32'h0001_0004, 1028, 0, 0);       // 257 DWords, R8
    run(3, 32'h0000_5000, 32'h0001_0040, 5, 0, 0);          // R5 tail 4'h1
    run(3, 32'h0000_5100, 32'h0001_0070, 63, 0, 1);         // R5 tail 4'h7, held valid
    run(0, 32'h0000_6000, 32'h0001_0000, 64, 3, 1);         // exact segment, R6
    ready_rand = 0; wr_ready = 0;
    fork
      run(1, 32'h0000_7000, 32'h0002_0010, 22, 0, 0);       // R11 long stall
      begin repeat (12) @(posedge clk); #1 wr_ready = 1; end
    join
    ready_rand = 1;
    for (int i = 0; i < 60; i++)
      run($urandom_range(0, 3), $urandom & 32'hFFFF_FF80, $urandom & 32'hFFFF_FFFC,
          $urandom_range(0, 1028), $urandom_range(0, 7), $urandom_range(0, 1));
    summary_done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule